// File: doc/BRIEF.md
# Hot path message profiler

This block sits beside a core's retirement stage and watches one retired instruction per cycle. When it sees a hint that hot code is about to run, it opens a message: a taken backward branch outside a trace, a call outside a trace, or an exit from a trace. The message records the PC of the instruction that opened it. Each conditional branch after that adds one taken/not-taken bit to the message. The message closes when a fixed number of branches has been recorded, or earlier when the core starts executing from a trace.

A closed message leaves as two flits on an in-order valid/ready channel. The first flit is the start PC. The second carries the outcome count and the outcome vector. Only one message may be outstanding at a time: after the second flit goes out, the block waits for an acknowledge pulse from the consumer. Any message that closes while a send is in progress or an acknowledge is pending is discarded. The builder and the sender work independently, so a new message can be opened and tracked while the channel is busy.

Top module: `hpm_profiler`

## Requirements
- R1: After reset, no flit is offered, no message is open and no acknowledge is pending.
- R2: An instruction that is not in a trace and is a taken branch whose target is lower than its own PC opens a message. A forward taken branch, a not-taken backward branch or a backward branch executed inside a trace opens none.
- R3: An instruction that is not in a trace and has the call flag set opens a message.
- R4: An instruction with the trace-exit flag set opens a message.
- R5: While a message is open, further start hints are ignored. The recorded start PC stays that of the opening instruction, and a call inside the message adds no outcome bit.
- R6: Every conditional branch after the opening instruction increments the length by one and shifts its taken bit into bit 0 of the vector, moving older bits up. The first branch therefore ends at bit length-1. The opening instruction itself is not counted.
- R7: A message closes on the branch that brings its length to BR_LIMIT (default 16). Its length field then reads BR_LIMIT.
- R8: An in-trace instruction while a message is open closes it at once as a short message with its current length, which may be zero. That instruction adds no outcome bit.
- R9: A closed message is sent as two flits. The first holds the PC, zero-extended. The second holds the length in its top LEN_W bits and the vector in its low BR_LIMIT bits, with zeros between. Each flit is held valid with stable data until flit_ready is high.
- R10: After the second flit is accepted, no flit is offered until ack pulses. Messages that close while a send or an acknowledge wait is in progress are dropped. An ack that arrives while nothing is awaited has no effect.
- R11: The first flit is offered in the cycle after the clock edge that samples the closing instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | A retired instruction is present this cycle |
| ins_pc | input | PC_W | PC of the retired instruction |
| ins_is_branch | input | 1 | Instruction is a conditional branch |
| ins_taken | input | 1 | Conditional branch was taken |
| ins_target | input | PC_W | Branch target address |
| ins_is_call | input | 1 | Instruction is a call (jump and link) |
| ins_in_trace | input | 1 | Instruction was fetched from a trace |
| ins_trace_exit | input | 1 | Instruction leaves a trace (early or regular exit) |
| ack | input | 1 | One-cycle acknowledge from the consumer |
| flit_valid | output | 1 | Flit offered on the channel |
| flit_data | output | FLIT_W | Flit payload |
| flit_ready | input | 1 | Channel accepts the offered flit |

## Verification
The bench attacks the start comparison at its edges: forward targets, not-taken backward branches and backward branches inside a trace. A design using the wrong comparison or ignoring the trace flag would emit unwanted messages. Calls and non-branches are injected inside open messages, which a design that restarts on a new hint would expose through a wrong start PC or a shifted vector. Zero-length and full-length messages with asymmetric patterns catch off-by-one limits and a reversed shift direction. The bench also closes messages during backpressure and during an acknowledge wait, and sends a stray acknowledge in idle. A design that queued, sent or pre-armed in those cases would offer extra flits.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  // Sender phases: idle, PC flit offered, body flit offered, awaiting ack
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PC   = 2'd1,
    TX_BODY = 2'd2,
    TX_WAIT = 2'd3
  } tx_state_e;
endpackage

// File: rtl/hpm_start_detect.sv
module hpm_start_detect #(
  parameter int PC_W = 32
) (
  input  logic            ins_valid,
  input  logic [PC_W-1:0] ins_pc,
  input  logic            ins_is_branch,
  input  logic            ins_taken,
  input  logic [PC_W-1:0] ins_target,
  input  logic            ins_is_call,
  input  logic            ins_in_trace,
  input  logic            ins_trace_exit,
  output logic            start_o
);
  logic loop_hint, call_hint, exit_hint;

  always_comb begin
    loop_hint = !ins_in_trace && ins_is_branch && ins_taken && (ins_target < ins_pc);
    call_hint = !ins_in_trace && ins_is_call;
    exit_hint = ins_trace_exit;
    start_o   = ins_valid && (loop_hint || call_hint || exit_hint);
  end
endmodule

// File: rtl/hpm_builder.sv
module hpm_builder #(
  parameter int PC_W     = 32,
  parameter int BR_LIMIT = 16,
  parameter int LEN_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ins_valid,
  input  logic [PC_W-1:0]     ins_pc,
  input  logic                ins_is_branch,
  input  logic                ins_taken,
  input  logic                ins_in_trace,
  input  logic                start_i,
  output logic                done_o,
  output logic [PC_W-1:0]     msg_pc_o,
  output logic [BR_LIMIT-1:0] msg_vec_o,
  output logic [LEN_W-1:0]    msg_len_o
);
  localparam logic [LEN_W-1:0] LIMIT_L = LEN_W'(BR_LIMIT);

  logic                open_q;
  logic [PC_W-1:0]     pc_q;
  logic [BR_LIMIT-1:0] vec_q;
  logic [LEN_W-1:0]    len_q;

  logic                br_hit, trace_in;
  logic [BR_LIMIT-1:0] vec_nx;
  logic [LEN_W-1:0]    len_nx;

  always_comb begin
    br_hit   = open_q && ins_valid && !ins_in_trace && ins_is_branch;
    trace_in = open_q && ins_valid && ins_in_trace;
    vec_nx   = br_hit ? {vec_q[BR_LIMIT-2:0], ins_taken} : vec_q;
    len_nx   = len_q + LEN_W'(br_hit);
    done_o   = trace_in || (br_hit && (len_nx == LIMIT_L));
    msg_pc_o  = pc_q;
    msg_vec_o = vec_nx;
    msg_len_o = len_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      pc_q   <= '0;
      vec_q  <= '0;
      len_q  <= '0;
    end else if (done_o) begin
      open_q <= 1'b0;
    end else if (start_i && !open_q) begin
      open_q <= 1'b1;
      pc_q   <= ins_pc;
      vec_q  <= '0;
      len_q  <= '0;
    end else if (br_hit) begin
      vec_q <= vec_nx;
      len_q <= len_nx;
    end
  end

  // R7
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    open_q |-> (len_q < LIMIT_L));

  // R8
  trace_close_chk: assert property (@(posedge clk) disable iff (rst)
    (open_q && ins_valid && ins_in_trace) |=> !open_q);
endmodule

// File: rtl/hpm_flit_tx.sv
module hpm_flit_tx
  import hpm_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int BR_LIMIT = 16,
  parameter int LEN_W    = 5,
  parameter int FLIT_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                done_i,
  input  logic [PC_W-1:0]     pc_i,
  input  logic [BR_LIMIT-1:0] vec_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                ack_i,
  input  logic                flit_ready_i,
  output logic                flit_valid_o,
  output logic [FLIT_W-1:0]   flit_data_o
);
  tx_state_e         state_q;
  logic [FLIT_W-1:0] body_q;
  logic [FLIT_W-1:0] pc_flit, body_flit;

  always_comb begin
    pc_flit = '0;
    pc_flit[PC_W-1:0] = pc_i;
    body_flit = '0;
    body_flit[BR_LIMIT-1:0] = vec_i;
    body_flit[FLIT_W-1 -: LEN_W] = len_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= TX_IDLE;
      body_q       <= '0;
      flit_valid_o <= 1'b0;
      flit_data_o  <= '0;
    end else begin
      case (state_q)
        TX_IDLE: if (done_i) begin
          flit_data_o  <= pc_flit;
          body_q       <= body_flit;
          flit_valid_o <= 1'b1;
          state_q      <= TX_PC;
        end
        TX_PC: if (flit_ready_i) begin
          flit_data_o <= body_q;
          state_q     <= TX_BODY;
        end
        TX_BODY: if (flit_ready_i) begin
          flit_valid_o <= 1'b0;
          state_q      <= TX_WAIT;
        end
        default: if (ack_i) state_q <= TX_IDLE;
      endcase
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flit_valid_o && !flit_ready_i) |=> (flit_valid_o && $stable(flit_data_o)));

  // R10
  ack_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_WAIT && !ack_i) |=> !flit_valid_o);

  // R11
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_IDLE && done_i) |=> (flit_valid_o && flit_data_o == $past(pc_flit)));
endmodule

// File: rtl/hpm_profiler.sv
module hpm_profiler #(
  parameter int PC_W     = 32,
  parameter int BR_LIMIT = 16,
  parameter int LEN_W    = 5,
  parameter int FLIT_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic              ins_is_branch,
  input  logic              ins_taken,
  input  logic [PC_W-1:0]   ins_target,
  input  logic              ins_is_call,
  input  logic              ins_in_trace,
  input  logic              ins_trace_exit,
  input  logic              ack,
  output logic              flit_valid,
  output logic [FLIT_W-1:0] flit_data,
  input  logic              flit_ready
);
  logic                start_w, done_w;
  logic [PC_W-1:0]     msg_pc_w;
  logic [BR_LIMIT-1:0] msg_vec_w;
  logic [LEN_W-1:0]    msg_len_w;

  hpm_start_detect #(.PC_W(PC_W)) u_detect (
    .ins_valid      (ins_valid),
    .ins_pc         (ins_pc),
    .ins_is_branch  (ins_is_branch),
    .ins_taken      (ins_taken),
    .ins_target     (ins_target),
    .ins_is_call    (ins_is_call),
    .ins_in_trace   (ins_in_trace),
    .ins_trace_exit (ins_trace_exit),
    .start_o        (start_w)
  );

  hpm_builder #(.PC_W(PC_W), .BR_LIMIT(BR_LIMIT), .LEN_W(LEN_W)) u_build (
    .clk           (clk),
    .rst           (rst),
    .ins_valid     (ins_valid),
    .ins_pc        (ins_pc),
    .ins_is_branch (ins_is_branch),
    .ins_taken     (ins_taken),
    .ins_in_trace  (ins_in_trace),
    .start_i       (start_w),
    .done_o        (done_w),
    .msg_pc_o      (msg_pc_w),
    .msg_vec_o     (msg_vec_w),
    .msg_len_o     (msg_len_w)
  );

  hpm_flit_tx #(.PC_W(PC_W), .BR_LIMIT(BR_LIMIT), .LEN_W(LEN_W), .FLIT_W(FLIT_W)) u_tx (
    .clk          (clk),
    .rst          (rst),
    .done_i       (done_w),
    .pc_i         (msg_pc_w),
    .vec_i        (msg_vec_w),
    .len_i        (msg_len_w),
    .ack_i        (ack),
    .flit_ready_i (flit_ready),
    .flit_valid_o (flit_valid),
    .flit_data_o  (flit_data)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !flit_valid);
endmodule

// File: tb/hpm_profiler_test.sv
`timescale 1ns/1ps
module hpm_profiler_test;
  localparam int LIMIT = 16;
  localparam int NCASE = 6;
  // kind: 0 backward branch, 1 call, 2 trace exit
  localparam int          C_KIND [NCASE] = '{0, 1, 2, 0, 1, 2};
  localparam logic [31:0] C_PC   [NCASE] = '{32'h0000_1000, 32'h0000_2040, 32'h0000_3000,
                                             32'h0000_4444, 32'hDEAD_BEE0, 32'h1234_5678};
  localparam int          C_N    [NCASE] = '{16, 3, 0, 16, 7, 16};
  localparam logic [15:0] C_PAT  [NCASE] = '{16'hA5C3, 16'h0005, 16'h0000,
                                             16'hFFFF, 16'h0013, 16'h0001};
  localparam logic [31:0] C_EXP  [NCASE] = '{32'h8000_A5C3, 32'h1800_0005, 32'h0000_0000,
                                             32'h8000_FFFF, 32'h3800_0013, 32'h8000_0001};

  logic clk = 1'b0, rst = 1'b1;
  logic iv = 0, ibr = 0, itk = 0, icall = 0, itr = 0, iex = 0, ack = 0, rdy = 1;
  logic [31:0] ipc = '0, itgt = '0;
  logic flit_valid;
  logic [31:0] flit_data;
  int n_chk = 0, n_fail = 0, ngot = 0;
  logic [31:0] got [64];
  bit finished = 0;

  always #10 clk = ~clk;

  hpm_profiler uut (
    .clk(clk), .rst(rst), .ins_valid(iv), .ins_pc(ipc), .ins_is_branch(ibr),
    .ins_taken(itk), .ins_target(itgt), .ins_is_call(icall), .ins_in_trace(itr),
    .ins_trace_exit(iex), .ack(ack), .flit_valid(flit_valid), .flit_data(flit_data),
    .flit_ready(rdy)
  );

  always @(negedge clk)
    if (flit_valid && rdy && ngot < 64) begin
      got[ngot] = flit_data;
      ngot++;
    end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [31:0] pc, logic br, logic tk, logic [31:0] tg,
                       logic cl, logic tr, logic ex);
    @(posedge clk); #2;
    iv = v; ipc = pc; ibr = br; itk = tk; itgt = tg; icall = cl; itr = tr; iex = ex;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pulse_ack();
    @(posedge clk); #2 ack = 1;
    @(posedge clk); #2 ack = 0;
  endtask

  task automatic run_case(int c);
    int base = ngot;
    logic [31:0] pc = C_PC[c];
    case (C_KIND[c])
      0: drive(1, pc, 1, 1, pc - 32'h40, 0, 0, 0);
      1: drive(1, pc, 0, 0, 0, 1, 0, 0);
      default: drive(1, pc, 0, 0, 0, 0, 0, 1);
    endcase
    for (int i = 0; i < C_N[c]; i++) begin
      drive(1, pc + 4 + 8*i, 1, C_PAT[c][C_N[c]-1-i], pc + 32'h100, 0, 0, 0);
      if (i == 0 && C_N[c] > 1) begin
        drive(1, 32'h0000_9000, 0, 0, 0, 1, 0, 0);   // R5 call ignored
        drive(1, 32'h0000_9004, 0, 0, 0, 0, 0, 0);
      end
    end
    if (C_N[c] < LIMIT) drive(1, 32'h0000_8000, 0, 0, 0, 0, 1, 0);   // R8 close
    idle(5);
    chk($sformatf("R9 case %0d flit count", c), ngot - base, 2);
    chk($sformatf("R5 R2 R3 R4 case %0d start pc", c), got[base], pc);
    chk($sformatf("R6 R7 R8 case %0d body", c), got[base+1], C_EXP[c]);
    pulse_ack();
    idle(2);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    idle(3);
    @(posedge clk); #2 rst = 0;
    @(negedge clk);
    chk("R1 no flit after reset", {31'b0, flit_valid}, 0);

    // R2 non-starting branches, then an in-trace instruction that would close
    base = ngot;
    drive(1, 32'h500, 1, 1, 32'h600, 0, 0, 0);
    drive(1, 32'h600, 1, 0, 32'h100, 0, 0, 0);
    drive(1, 32'h700, 1, 1, 32'h100, 0, 1, 0);
    drive(1, 32'h704, 0, 0, 0, 0, 1, 0);
    idle(6);
    chk("R2 no message from non-hints", ngot - base, 0);

    // table of message cases
    for (int c = 0; c < NCASE; c++) run_case(c);

    // R10 drop while awaiting ack, stray ack ignored
    base = ngot;
    drive(1, 32'hA000, 0, 0, 0, 1, 0, 0);
    drive(1, 32'h8000, 0, 0, 0, 0, 1, 0);
    idle(4);
    drive(1, 32'hB000, 0, 0, 0, 1, 0, 0);
    drive(1, 32'h8000, 0, 0, 0, 0, 1, 0);
    idle(8);
    chk("R10 second message dropped", ngot - base, 2);
    chk("R10 first message pc", got[base], 32'hA000);
    pulse_ack();
    drive(1, 32'hC000, 0, 0, 0, 1, 0, 0);
    drive(1, 32'h8000, 0, 0, 0, 0, 1, 0);
    idle(5);
    chk("R10 sent after ack", got[base+2], 32'hC000);
    chk("R8 zero length body", got[base+3], 32'h0);
    pulse_ack();
    pulse_ack();   // stray
    drive(1, 32'hD100, 0, 0, 0, 1, 0, 0);
    drive(1, 32'h8000, 0, 0, 0, 0, 1, 0);
    idle(4);
    drive(1, 32'hD200, 0, 0, 0, 1, 0, 0);
    drive(1, 32'h8000, 0, 0, 0, 0, 1, 0);
    idle(6);
    chk("R10 stray ack not pre-armed", ngot - base, 6);
    pulse_ack();

    // R9 R11 backpressure and launch timing
    base = ngot;
    @(posedge clk); #2 rdy = 0;
    drive(1, 32'hD000, 0, 0, 0, 1, 0, 0);
    drive(1, 32'h8000, 0, 0, 0, 0, 1, 0);
    @(negedge clk);
    chk("R11 not yet valid", {31'b0, flit_valid}, 0);
    idle(1);
    @(negedge clk);
    chk("R11 valid next cycle", {31'b0, flit_valid}, 1);
    chk("R11 first flit pc", flit_data, 32'hD000);
    drive(1, 32'hE000, 0, 0, 0, 1, 0, 0);
    drive(1, 32'h8000, 0, 0, 0, 0, 1, 0);
    idle(3);
    @(negedge clk);
    chk("R9 held valid", {31'b0, flit_valid}, 1);
    chk("R9 held data", flit_data, 32'hD000);
    @(posedge clk); #2 rdy = 1;
    idle(5);
    pulse_ack();
    idle(4);
    chk("R10 busy completion dropped", ngot - base, 2);
    chk("R9 backpressured body", got[base+1], 32'h0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule